// File: doc/BRIEF.md
# Staged-Ratio Clock Divider

This block divides its input clock by an integer between 1 and 16. Software chooses the ratio by writing a 4-bit field into a 32-bit control word. Writing the field alone changes nothing at the output. The new ratio reaches the divider only when a separate load bit in the same word goes from 0 to 1.

That 0-to-1 change produces a pulse one input cycle wide. The pulse hands the staged ratio to the divider. The divider adopts it only when its counter wraps, so every output period runs to completion at either the old ratio or the new one.

Two outputs come from the divider:
- `clk_o` is the divided clock. At ratio 1 it is the input clock passed through a glitch-free gate.
- `clk_en_o` marks the first input cycle of every output period, so downstream logic can run on the input clock instead.

Top module: `stgdiv_top`

## Requirements
- R1: The output period equals (divide field + 1) input cycles, for every field value from 0 to 15 (ratios 1 to 16). `clk_en_o` is high for exactly one input cycle at the start of each output period.
- R2: After reset, the control word reads 0 and the divider runs at ratio 1.
- R3: A write that changes only the divide field (bits 3:0), with the load bit (bit 8) written as 0, leaves the output period unchanged.
- R4: The load bit is stored as written. When its stored value goes from 0 to 1, the staged divide field is transferred to the divider.
- R5: Writing the load bit as 1 again while it already holds 1 produces no further transfer, even if the divide field changed in the meantime. The load pulse lasts one input cycle.
- R6: A single write that sets the load bit and also changes the divide field transfers the divide value stored before that write, not the value written with it.
- R7: Register layout: the divide field is bits 3:0 and the load bit is bit 8. All other bits read as 0 and ignore written values.
- R8: A read returns the stored divide field and load bit in their bit positions.
- R9: A newly loaded ratio takes effect only at the end of a full output period. Each output period is the whole old length or the whole new length, never shorter.
- R10: For ratios above 1, `clk_o` is high for floor(ratio/2) input cycles at the start of each period. At ratio 1, `clk_o` follows `clk_i` and `clk_en_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word write data |
| rd_data_o | output | 32 | Control word read data |
| clk_o | output | 1 | Divided output clock |
| clk_en_o | output | 1 | One-cycle strobe at the start of each output period |

## Verification
The ratio is swept across even, odd and extreme values (2, 3, 5, 8, 16 and the bypass ratio of 1). Each value is followed by a measurement of period length and high time, which separates an off-by-one count from a wrong duty split.

The load protocol is tested with four write patterns:
- The field is written without a load, which must leave the output unchanged.
- The load bit is rewritten while already set, which must not reload.
- The load bit is set in the same write as a new field, which must load the previous field.
- A normal clear-then-set sequence, which must load the new field.

A switch from ratio 16 to ratio 3 is recorded over several consecutive periods. Each period must be whole, and the change must not reverse.

// File: rtl/stgdiv_pkg.sv
package stgdiv_pkg;

    localparam int unsigned CFG_DATA_W = 32;
    localparam int unsigned CFG_RATIO_W = 4;
    localparam int unsigned CFG_ARM_POS = 8;

    typedef struct packed {
        logic                   arm;
        logic [CFG_RATIO_W-1:0] ratio;
    } ctl_word_t;

    typedef struct packed {
        logic                   fire;
        logic [CFG_RATIO_W-1:0] value;
    } load_req_t;

    // Number of input cycles the output stays high for a period of n cycles.
    function automatic logic [CFG_RATIO_W:0] high_len(input logic [CFG_RATIO_W-1:0] code);
        logic [CFG_RATIO_W:0] n;
        n = {1'b0, code} + 1'b1;
        return n >> 1;
    endfunction

endpackage

// File: rtl/stgdiv_regs.sv
module stgdiv_regs
    import stgdiv_pkg::*;
#(
    parameter int unsigned DATA_W  = CFG_DATA_W,
    parameter int unsigned RATIO_W = CFG_RATIO_W,
    parameter int unsigned ARM_POS = CFG_ARM_POS
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output ctl_word_t         ctl_o
);

    ctl_word_t ctl_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q <= '0;
        end else if (wr_en_i) begin
            ctl_q.ratio <= wr_data_i[RATIO_W-1:0];
            ctl_q.arm   <= wr_data_i[ARM_POS];
        end
    end

    always_comb begin
        rd_data_o                = '0;
        rd_data_o[RATIO_W-1:0]   = ctl_q.ratio;
        rd_data_o[ARM_POS]       = ctl_q.arm;
    end

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data_i[DATA_W-1:ARM_POS+1], wr_data_i[ARM_POS-1:RATIO_W]};

    assign ctl_o = ctl_q;

    // R4: the stored load bit follows the written bit 8
    p_arm_stored_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_i |=> (rd_data_o[ARM_POS] == $past(wr_data_i[ARM_POS])));

    // R7: without a write, the register content holds
    p_hold_no_write_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_en_i |=> $stable(rd_data_o));

endmodule

// File: rtl/stgdiv_loadgen.sv
module stgdiv_loadgen
    import stgdiv_pkg::*;
#(
    parameter int unsigned RATIO_W = CFG_RATIO_W
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  ctl_word_t ctl_i,
    output load_req_t req_o
);

    logic               arm_d1_q;
    logic [RATIO_W-1:0] ratio_d1_q;

    // The ratio is delayed alongside the arm bit, so the pulse carries the
    // value staged before the write that raised the arm bit.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            arm_d1_q   <= 1'b0;
            ratio_d1_q <= '0;
        end else begin
            arm_d1_q   <= ctl_i.arm;
            ratio_d1_q <= ctl_i.ratio;
        end
    end

    assign req_o.fire  = ctl_i.arm & ~arm_d1_q;
    assign req_o.value = ratio_d1_q;

    // R5: the load pulse lasts one cycle
    p_single_pulse_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        req_o.fire |=> !req_o.fire);

    // R4: a pulse is preceded by a cleared load bit
    p_fire_on_rise_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        req_o.fire |-> $rose(ctl_i.arm));

endmodule

// File: rtl/stgdiv_core.sv
module stgdiv_core
    import stgdiv_pkg::*;
#(
    parameter int unsigned RATIO_W = CFG_RATIO_W
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  load_req_t req_i,
    output logic      clk_o,
    output logic      clk_en_o
);

    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] act_q;
    logic [RATIO_W-1:0] pend_q;
    logic               pend_vld_q;
    logic               div_q;
    logic               en_q;
    logic               gate_q;

    logic               wrap;
    logic [RATIO_W-1:0] cnt_nxt;
    logic [RATIO_W-1:0] act_nxt;
    logic [RATIO_W:0]   hi_nxt;

    always_comb begin
        wrap    = (cnt_q == act_q);
        cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
        act_nxt = (wrap && pend_vld_q) ? pend_q : act_q;
        hi_nxt  = high_len(act_nxt);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q      <= '0;
            act_q      <= '0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            div_q      <= 1'b0;
            en_q       <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            act_q <= act_nxt;
            if (wrap) begin
                pend_vld_q <= 1'b0;
            end
            if (req_i.fire) begin
                pend_q     <= req_i.value;
                pend_vld_q <= 1'b1;
            end
            div_q <= (act_nxt != '0) && ({1'b0, cnt_nxt} < hi_nxt);
            en_q  <= (cnt_nxt == '0);
        end
    end

    // Bypass gate for ratio 1: updated while the input clock is low.
    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            gate_q <= 1'b1;
        end else begin
            gate_q <= (act_q == '0);
        end
    end

    assign clk_o    = div_q | (clk_i & gate_q);
    assign clk_en_o = en_q;

    // R9: the counter never runs past the active ratio
    p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= act_q);

    // R9: the active ratio changes only at a counter wrap
    p_switch_at_wrap_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(act_q) |-> ($past(cnt_q) == $past(act_q)));

    // R1: a period start is followed by a counter at zero
    p_en_at_zero_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        en_q |-> (cnt_q == '0));

endmodule

// File: rtl/stgdiv_top.sv
module stgdiv_top
    import stgdiv_pkg::*;
#(
    parameter int unsigned DATA_W  = CFG_DATA_W,
    parameter int unsigned RATIO_W = CFG_RATIO_W,
    parameter int unsigned ARM_POS = CFG_ARM_POS
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              clk_o,
    output logic              clk_en_o
);

    ctl_word_t ctl;
    load_req_t req;

    stgdiv_regs #(
        .DATA_W  (DATA_W),
        .RATIO_W (RATIO_W),
        .ARM_POS (ARM_POS)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .ctl_o     (ctl)
    );

    stgdiv_loadgen #(
        .RATIO_W (RATIO_W)
    ) u_loadgen (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ctl_i (ctl),
        .req_o (req)
    );

    stgdiv_core #(
        .RATIO_W (RATIO_W)
    ) u_core (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .req_i    (req),
        .clk_o    (clk_o),
        .clk_en_o (clk_en_o)
    );

endmodule

// File: tb/test_stgdiv_top.sv
`timescale 1ns/1ps
module test_stgdiv_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        clk_o;
    logic        clk_en_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    stgdiv_top i_stgdiv_top (
        .clk_i     (clk),
        .rst_i     (rst),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .clk_o     (clk_o),
        .clk_en_o  (clk_en_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    // Full stage-and-load sequence: field with load cleared, then load set.
    task automatic load_ratio(input int code);
        write_word(32'(code));
        write_word(32'h100 | 32'(code));
    endtask

    // Measures one full output period: length and high cycles.
    task automatic measure(output int len, output int hi);
        int guard = 0;
        tick();
        while (!clk_en_o && guard < 40) begin
            tick();
            guard++;
        end
        len = 0;
        hi  = 0;
        do begin
            if (clk_o) hi++;
            len++;
            tick();
        end while (!clk_en_o && len < 40);
    endtask

    task automatic expect_ratio(input string req, input int n);
        int len;
        int hi;
        repeat (40) tick();
        measure(len, hi);
        check(req, len, n);
        if (n > 1) check("R10 high time", hi, n / 2);
    endtask

    task automatic expect_bypass(input string req);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            #2;
            check(req, int'(clk_o), 1);
            check(req, int'(clk_en_o), 1);
            #4;
            check(req, int'(clk_o), 0);
        end
    endtask

    task automatic t_reset();
        tick();
        check("R2 read after reset", int'(rd_data), 0);
        expect_bypass("R2 ratio 1 after reset");
    endtask

    task automatic t_sweep();
        int codes[5] = '{1, 2, 4, 7, 15};
        foreach (codes[i]) begin
            load_ratio(codes[i]);
            expect_ratio("R1 R4 ratio sweep", codes[i] + 1);
        end
        load_ratio(0);
        repeat (40) tick();
        expect_bypass("R10 ratio 1 bypass");
    endtask

    task automatic t_stage_only();
        load_ratio(3);
        expect_ratio("R4 load 4", 4);
        write_word(32'h0000_0009);
        tick();
        check("R8 read staged", int'(rd_data), 9);
        expect_ratio("R3 staged without load", 4);
    endtask

    task automatic t_no_reclear();
        load_ratio(5);
        expect_ratio("R4 load 6", 6);
        write_word(32'h0000_0102);
        tick();
        check("R8 read arm and field", int'(rd_data), 32'h102);
        expect_ratio("R5 arm rewritten while set", 6);
        write_word(32'h0000_0002);
        write_word(32'h0000_0102);
        expect_ratio("R4 reload after clear", 3);
    endtask

    task automatic t_same_write();
        load_ratio(3);
        expect_ratio("R6 base", 4);
        write_word(32'h0000_0005);
        write_word(32'h0000_0005);
        write_word(32'h0000_0109);
        expect_ratio("R6 same-write loads previous", 6);
        tick();
        check("R6 read new field", int'(rd_data), 32'h109);
        write_word(32'h0000_0009);
        write_word(32'h0000_0109);
        expect_ratio("R6 later load of new field", 10);
    endtask

    task automatic t_reserved();
        write_word(32'hFFFF_FFFF);
        tick();
        check("R7 reserved bits read 0", int'(rd_data), 32'h10F);
        write_word(32'hFFFF_FEF0);
        tick();
        check("R7 write with reserved set", int'(rd_data), 32'h000);
    endtask

    task automatic t_clean_switch();
        int len;
        int hi;
        bit seen_new = 0;
        load_ratio(15);
        repeat (40) tick();
        write_word(32'h0000_0002);
        write_word(32'h0000_0102);
        for (int p = 0; p < 6; p++) begin
            measure(len, hi);
            if (len == 3) seen_new = 1;
            if (seen_new) check("R9 period after switch", len, 3);
            else check("R9 period before switch", len, 16);
            check("R10 high time across switch", hi, len / 2);
        end
        check("R9 new ratio reached", int'(seen_new), 1);
    endtask

    initial begin
        rst     = 1'b1;
        wr_en   = 1'b0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sweep();
        t_stage_only();
        t_no_reclear();
        t_same_write();
        t_reserved();
        t_clean_switch();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule